// File: doc/BRIEF.md
# Dual-Half SECDED Read Checker

The block sits on the read path of a flash array and examines one 128-bit line per accepted read. The line is split into a lower and an upper 64-bit half, each guarded by its own 8 check bits. A single flipped bit in a half is repaired before the line leaves the block. Each half also gets a descriptor for a downstream error logger. The descriptor says whether a repair happened, whether the bad bit was a data bit or a check bit, where it sat, and which value the bit was restored to. Faults that cannot be repaired are flagged, both for the whole line and for the half the requester actually addressed.

The read address is folded into each half's code, so a line fetched from the wrong location shows up as an uncorrectable fault rather than as clean data. A global enable lets software bypass the check; the line then passes through untouched and every error flag stays low.

Reads arrive on a valid/ready stream and results leave on a valid/ready stream, with one register stage between them. The input is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready` follows `out_ready` when a result is pending. A result that is not taken stays unchanged on the output, and `out_valid` stays high, until `out_ready` is seen.

Top module: `dual_secded_rd_check`

## Requirements
- R1: The check byte of half h is the XOR of a column for every set bit of the half's data and of the address vector {in_addr, h}, where bit 0 of that vector is the half index. Data column k is the k-th value, in ascending numeric order, among the 8-bit values of weight 3, followed by those of weight 5. Address column i is the i-th value among weight 2 values, then weight 4. A half whose stored check byte matches returns its data unchanged with no flag set.
- R2: A single flipped data bit k in a half is inverted back in `out_data`, `out_sec` is set for that half, `out_chk_err` is 0, and the half's 6-bit field of `out_pos` (bits 6h+5..6h) reads k. When `out_sec` of a half is 0, its position, type and fix flags read 0.
- R3: A single flipped check bit j leaves the data unchanged, sets `out_sec` and `out_chk_err` for the half, and the position field reads j.
- R4: For a repaired half exactly one of `out_fix1` and `out_fix0` is set: `out_fix1` when the restored bit value is 1, `out_fix0` when it is 0.
- R5: Per-half outputs use bit 0 for the lower half (data bits 63..0, check bits 7..0) and bit 1 for the upper half, and the two halves are checked independently.
- R6: Two flipped bits in a half, in data, check bits or both, set `out_unc_half` for that half, leave `out_sec` clear and return that half's data as read.
- R7: A read whose address differs from the written address in any single bit sets `out_unc_half` for both halves.
- R8: `out_unc_line` is set when either half, or both, is uncorrectable, whichever half was accessed.
- R9: `out_unc_access` is set only when the half selected by `in_half` is uncorrectable.
- R10: With `ecc_en` low the data passes through unchanged and all error outputs are 0.
- R11: A read accepted at a clock edge is presented with `out_valid` high after that edge, together with the echoed `out_addr` and `out_half`.
- R12: While `out_valid` is high and `out_ready` is low, the output stays stable and `in_ready` is 0.
- R13: During reset `out_valid` is 0 and `in_ready` is 1, and a pending result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enables checking and repair |
| in_valid | input | 1 | Read line is present |
| in_ready | output | 1 | Block can take the read line |
| in_addr | input | ADDR_W | Line address of the read |
| in_half | input | 1 | Half addressed by the requester (0 lower, 1 upper) |
| in_data | input | 128 | Raw line data, lower half in bits 63..0 |
| in_chk | input | 16 | Raw check bytes, lower half in bits 7..0 |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Repaired line data |
| out_addr | output | ADDR_W | Echoed line address |
| out_half | output | 1 | Echoed accessed half |
| out_sec | output | 2 | Per half: a single bit was repaired |
| out_chk_err | output | 2 | Per half: the repaired bit was a check bit |
| out_pos | output | 12 | Per half 6-bit position of the repaired bit |
| out_fix0 | output | 2 | Per half: repaired bit restored to 0 |
| out_fix1 | output | 2 | Per half: repaired bit restored to 1 |
| out_unc_half | output | 2 | Per half: uncorrectable fault |
| out_unc_line | output | 1 | Uncorrectable fault anywhere in the line |
| out_unc_access | output | 1 | Uncorrectable fault in the accessed half |

## Verification
The bench builds the block with ADDR_W set to 8. At that width every address bit can be flipped on its own, which drives each even-weight address column into the syndrome and shows that none of them reaches a repair. The code columns do not depend on the parameter, so the sweep of all 72 single-bit positions in both halves covers the whole repair table at this width as well.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int HALF_DW      = 64;
  localparam int HALF_CW      = 8;
  localparam int POS_W        = 6;
  localparam int NUM_HALVES   = 2;
  // weight-2 plus weight-4 columns available for address folding
  localparam int ADDR_COL_CNT = 98;

  typedef struct packed {
    logic             sec;
    logic             chk_err;
    logic [POS_W-1:0] pos;
    logic             fix0;
    logic             fix1;
    logic             unc;
  } half_stat_t;

  function automatic int popc(input logic [HALF_CW-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < HALF_CW; i++) begin
      if (v[i]) c++;
    end
    return c;
  endfunction

  // n-th column taken from weight w_first values, then weight w_next values
  function automatic logic [HALF_CW-1:0] pick_col(input int n, input int w_first,
                                                  input int w_next);
    int seen;
    int want;
    logic [HALF_CW-1:0] res;
    seen = 0;
    res  = '0;
    for (int pass = 0; pass < 2; pass++) begin
      want = (pass == 0) ? w_first : w_next;
      for (int v = 1; v < (1 << HALF_CW); v++) begin
        if (popc(HALF_CW'(v)) == want) begin
          if (seen == n) res = HALF_CW'(v);
          seen++;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [HALF_DW-1:0][HALF_CW-1:0] build_data_cols();
    logic [HALF_DW-1:0][HALF_CW-1:0] t;
    for (int k = 0; k < HALF_DW; k++) t[k] = pick_col(k, 3, 5);
    return t;
  endfunction

  function automatic logic [ADDR_COL_CNT-1:0][HALF_CW-1:0] build_addr_cols();
    logic [ADDR_COL_CNT-1:0][HALF_CW-1:0] t;
    for (int i = 0; i < ADDR_COL_CNT; i++) t[i] = pick_col(i, 2, 4);
    return t;
  endfunction

  localparam logic [HALF_DW-1:0][HALF_CW-1:0]      DATA_COL = build_data_cols();
  localparam logic [ADDR_COL_CNT-1:0][HALF_CW-1:0] ADDR_COL = build_addr_cols();

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic [HALF_DW-1:0] data,
  input  logic [HALF_CW-1:0] chk,
  input  logic [AW-1:0]      addr,
  output logic [HALF_CW-1:0] syn
);

  // stored check byte against one recomputed from data and address
  always_comb begin
    syn = chk;
    for (int k = 0; k < HALF_DW; k++) begin
      if (data[k]) syn = syn ^ DATA_COL[k];
    end
    for (int i = 0; i < AW; i++) begin
      if (addr[i]) syn = syn ^ ADDR_COL[i];
    end
  end

endmodule

// File: rtl/secded_half_fix.sv
module secded_half_fix
  import secded_pkg::*;
(
  input  logic [HALF_CW-1:0] syn,
  input  logic [HALF_DW-1:0] data,
  input  logic [HALF_CW-1:0] chk,
  output logic [HALF_DW-1:0] data_fix,
  output half_stat_t         stat
);

  logic [HALF_DW-1:0] hit;
  logic               data_hit;
  logic               chk_hit;
  logic               fix_val;
  logic [POS_W-1:0]   pos;

  genvar k;
  generate
    for (k = 0; k < HALF_DW; k++) begin : g_match
      assign hit[k] = (syn == DATA_COL[k]);
    end
  endgenerate

  assign data_hit = |hit;
  // a unit syndrome points at a check bit
  assign chk_hit  = (syn != '0) && ((syn & (syn - HALF_CW'(1))) == '0);

  always_comb begin
    pos = '0;
    for (int i = 0; i < HALF_DW; i++) begin
      if (hit[i]) pos = POS_W'(i);
    end
    for (int j = 0; j < HALF_CW; j++) begin
      if (chk_hit && syn[j]) pos = POS_W'(j);
    end
  end

  assign fix_val  = data_hit ? |(hit & ~data) : |(syn & ~chk);
  assign data_fix = data ^ hit;

  always_comb begin
    stat.sec     = data_hit | chk_hit;
    stat.chk_err = chk_hit;
    stat.pos     = pos;
    stat.fix1    = (data_hit | chk_hit) & fix_val;
    stat.fix0    = (data_hit | chk_hit) & ~fix_val;
    stat.unc     = (syn != '0) & ~(data_hit | chk_hit);
  end

endmodule

// File: rtl/secded_pipe_reg.sv
module secded_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12
  AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11

endmodule

// File: rtl/dual_secded_rd_check.sv
module dual_secded_rd_check
  import secded_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ecc_en,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic                          in_half,
  input  logic [NUM_HALVES*HALF_DW-1:0] in_data,
  input  logic [NUM_HALVES*HALF_CW-1:0] in_chk,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [NUM_HALVES*HALF_DW-1:0] out_data,
  output logic [ADDR_W-1:0]             out_addr,
  output logic                          out_half,
  output logic [NUM_HALVES-1:0]         out_sec,
  output logic [NUM_HALVES-1:0]         out_chk_err,
  output logic [NUM_HALVES*POS_W-1:0]   out_pos,
  output logic [NUM_HALVES-1:0]         out_fix0,
  output logic [NUM_HALVES-1:0]         out_fix1,
  output logic [NUM_HALVES-1:0]         out_unc_half,
  output logic                          out_unc_line,
  output logic                          out_unc_access
);

  localparam int LINE_W = NUM_HALVES * HALF_DW;
  localparam int AV_W   = ADDR_W + 1;
  localparam int PAY_W  = LINE_W + ADDR_W + 1 + 5 * NUM_HALVES + NUM_HALVES * POS_W + 2;

  logic [HALF_DW-1:0] fixed [NUM_HALVES];
  half_stat_t         stat  [NUM_HALVES];

  genvar h;
  generate
    for (h = 0; h < NUM_HALVES; h++) begin : g_half
      logic [AV_W-1:0]    addr_vec;
      logic [HALF_CW-1:0] syn;

      assign addr_vec = {in_addr, 1'(h)};

      secded_syndrome #(.AW(AV_W)) u_syn (
        .data (in_data[h*HALF_DW +: HALF_DW]),
        .chk  (in_chk[h*HALF_CW +: HALF_CW]),
        .addr (addr_vec),
        .syn  (syn)
      );

      secded_half_fix u_fix (
        .syn      (syn),
        .data     (in_data[h*HALF_DW +: HALF_DW]),
        .chk      (in_chk[h*HALF_CW +: HALF_CW]),
        .data_fix (fixed[h]),
        .stat     (stat[h])
      );
    end
  endgenerate

  logic [LINE_W-1:0]           nxt_data;
  logic [NUM_HALVES-1:0]       nxt_sec, nxt_ce, nxt_f0, nxt_f1, nxt_unc;
  logic [NUM_HALVES*POS_W-1:0] nxt_pos;
  logic                        nxt_line, nxt_acc;

  always_comb begin
    for (int i = 0; i < NUM_HALVES; i++) begin
      nxt_data[i*HALF_DW +: HALF_DW] = ecc_en ? fixed[i] : in_data[i*HALF_DW +: HALF_DW];
      nxt_sec[i]                     = ecc_en & stat[i].sec;
      nxt_ce[i]                      = ecc_en & stat[i].chk_err;
      nxt_f0[i]                      = ecc_en & stat[i].fix0;
      nxt_f1[i]                      = ecc_en & stat[i].fix1;
      nxt_unc[i]                     = ecc_en & stat[i].unc;
      nxt_pos[i*POS_W +: POS_W]      = ecc_en ? stat[i].pos : '0;
    end
    nxt_line = |nxt_unc;
    nxt_acc  = nxt_unc[in_half];
  end

  logic [PAY_W-1:0] pay_d, pay_q;

  assign pay_d = {nxt_data, in_addr, in_half, nxt_sec, nxt_ce, nxt_pos,
                  nxt_f0, nxt_f1, nxt_unc, nxt_line, nxt_acc};

  secded_pipe_reg #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_q)
  );

  assign {out_data, out_addr, out_half, out_sec, out_chk_err, out_pos,
          out_fix0, out_fix1, out_unc_half, out_unc_line, out_unc_access} = pay_q;

  AST_ACCESS_IMPLIES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unc_access |-> out_unc_line); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ecc_en |=> out_sec == '0 && out_unc_half == '0
      && !out_unc_line && out_data == $past(in_data)); // R10

  generate
    for (h = 0; h < NUM_HALVES; h++) begin : g_chk
      AST_SEC_UNC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sec[h] && out_unc_half[h])); // R6
      AST_FIX_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sec[h] |-> $countones({out_fix0[h], out_fix1[h]}) == 1); // R4
      AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sec[h] |-> out_pos[h*POS_W +: POS_W] == '0
          && !out_chk_err[h] && !out_fix0[h] && !out_fix1[h]); // R2
    end
  endgenerate

endmodule

// File: tb/dual_secded_rd_check_bench.sv
`timescale 1ns/1ps
module dual_secded_rd_check_bench;

  localparam int         AW   = 8;
  localparam logic [7:0] NA   = 8'd255;
  localparam logic [7:0] BASE = 8'h5C;
  localparam int         NV   = 13;

  // {pat, lo_a, lo_b, hi_a, hi_b, addr_xor, acc_half, exp_sec, exp_unc}
  localparam logic [46:0] TV [NV] = '{
    {2'd0, NA,    NA,    NA,    NA,    8'h00, 1'b0, 2'b00, 2'b00}, // R1 clean
    {2'd3, NA,    NA,    NA,    NA,    8'h00, 1'b1, 2'b00, 2'b00}, // R1 clean
    {2'd1, 8'd5,  NA,    NA,    NA,    8'h00, 1'b0, 2'b01, 2'b00}, // R2
    {2'd2, NA,    NA,    8'd63, NA,    8'h00, 1'b1, 2'b10, 2'b00}, // R2 R5
    {2'd3, 8'd64, NA,    8'd71, NA,    8'h00, 1'b0, 2'b11, 2'b00}, // R3
    {2'd3, 8'd0,  NA,    8'd30, NA,    8'h00, 1'b1, 2'b11, 2'b00}, // R2 R4
    {2'd1, 8'd10, 8'd11, NA,    NA,    8'h00, 1'b0, 2'b00, 2'b01}, // R6 R9
    {2'd2, NA,    NA,    8'd3,  8'd68, 8'h00, 1'b0, 2'b00, 2'b10}, // R8 access clear
    {2'd2, NA,    NA,    8'd3,  8'd68, 8'h00, 1'b1, 2'b00, 2'b10}, // R9 access set
    {2'd0, NA,    NA,    NA,    NA,    8'h01, 1'b0, 2'b00, 2'b11}, // R7
    {2'd3, NA,    NA,    NA,    NA,    8'h80, 1'b1, 2'b00, 2'b11}, // R7
    {2'd3, 8'd65, 8'd66, 8'd40, NA,    8'h00, 1'b1, 2'b10, 2'b01}, // R5 R6
    {2'd1, 8'd70, NA,    NA,    NA,    8'h00, 1'b0, 2'b01, 2'b00}  // R3 R4
  };

  logic          clk = 1'b0;
  logic          rst_n, ecc_en, in_valid, in_ready, in_half, out_valid, out_ready;
  logic [AW-1:0] in_addr, out_addr;
  logic [127:0]  in_data, out_data;
  logic [15:0]   in_chk;
  logic          out_half, out_unc_line, out_unc_access;
  logic [1:0]    out_sec, out_chk_err, out_fix0, out_fix1, out_unc_half;
  logic [11:0]   out_pos;

  always #2.5 clk = ~clk;

  dual_secded_rd_check #(.ADDR_W(AW)) u_dual_secded_rd_check (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_half(in_half), .in_data(in_data), .in_chk(in_chk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_addr(out_addr), .out_half(out_half), .out_sec(out_sec),
    .out_chk_err(out_chk_err), .out_pos(out_pos), .out_fix0(out_fix0),
    .out_fix1(out_fix1), .out_unc_half(out_unc_half), .out_unc_line(out_unc_line),
    .out_unc_access(out_unc_access)
  );

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;
  bit case_bad;

  logic [7:0] bdc [64];
  logic [7:0] bac [9];

  logic [127:0] drv_data, exp_data;
  logic [15:0]  drv_chk;
  logic [AW-1:0] drv_addr;
  logic          drv_half;
  logic [1:0]    exp_sec, exp_ce, exp_f0, exp_f1, exp_unc;
  logic [11:0]   exp_pos;
  logic          exp_line, exp_acc;

  function automatic logic [7:0] bench_chk(input logic [63:0] d, input logic [7:0] a,
                                           input logic h);
    logic [7:0] r;
    logic [8:0] av;
    r  = 8'h00;
    av = {a, h};
    for (int k = 0; k < 64; k++) if (d[k]) r = r ^ bdc[k];
    for (int i = 0; i < 9; i++) if (av[i]) r = r ^ bac[i];
    return r;
  endfunction

  function automatic logic [127:0] pattern(input logic [1:0] p);
    case (p)
      2'd0:    return '0;
      2'd1:    return '1;
      2'd2:    return {16{8'hA5}};
      default: return {64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF};
    endcase
  endfunction

  task automatic cmp(input string tag, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    if (act !== exp) begin
      case_bad = 1'b1;
      $display("FAIL [%s] %s %s act=%h exp=%h", tag, req, what, act, exp);
    end
  endtask

  // builds drive values and expectations from the requirement rules
  task automatic prep(input logic [127:0] d0, input logic [7:0] la, input logic [7:0] lb,
                      input logic [7:0] ha, input logic [7:0] hb, input logic [7:0] axor,
                      input logic acc, input logic en, input logic [1:0] esec,
                      input logic [1:0] eunc);
    for (int h = 0; h < 2; h++) begin
      logic [63:0] od, rd;
      logic [7:0]  oc, rc, fa, fb;
      od = d0[h*64 +: 64];
      oc = bench_chk(od, BASE, h[0]);
      rd = od;
      rc = oc;
      fa = (h == 0) ? la : ha;
      fb = (h == 0) ? lb : hb;
      if (fa != NA) begin if (fa < 64) rd[fa] = ~rd[fa]; else rc[fa-64] = ~rc[fa-64]; end
      if (fb != NA) begin if (fb < 64) rd[fb] = ~rd[fb]; else rc[fb-64] = ~rc[fb-64]; end
      drv_data[h*64 +: 64] = rd;
      drv_chk[h*8 +: 8]    = rc;
      exp_sec[h] = 1'b0; exp_ce[h] = 1'b0; exp_f0[h] = 1'b0; exp_f1[h] = 1'b0;
      exp_pos[h*6 +: 6] = 6'd0;
      exp_data[h*64 +: 64] = rd;
      if (en && esec[h]) begin
        logic orig;
        exp_sec[h] = 1'b1;
        exp_ce[h]  = (fa >= 64);
        exp_pos[h*6 +: 6] = (fa >= 64) ? 6'(fa - 64) : 6'(fa);
        orig = (fa >= 64) ? oc[fa-64] : od[fa];
        exp_f1[h] = orig;
        exp_f0[h] = ~orig;
        exp_data[h*64 +: 64] = od;
      end
    end
    exp_unc  = en ? eunc : 2'b00;
    exp_line = |exp_unc;
    exp_acc  = exp_unc[acc];
    drv_addr = BASE ^ axor;
    drv_half = acc;
  endtask

  task automatic check_out(input string tag);
    case_bad = 1'b0;
    tests_run++;
    cmp(tag, "R11", "out_valid", 128'(out_valid), 128'(1'b1));
    cmp(tag, "R11", "out_addr", 128'(out_addr), 128'(drv_addr));
    cmp(tag, "R11", "out_half", 128'(out_half), 128'(drv_half));
    cmp(tag, "R2", "out_data", out_data, exp_data);
    cmp(tag, "R5", "out_sec", 128'(out_sec), 128'(exp_sec));
    cmp(tag, "R3", "out_chk_err", 128'(out_chk_err), 128'(exp_ce));
    cmp(tag, "R2", "out_pos", 128'(out_pos), 128'(exp_pos));
    cmp(tag, "R4", "out_fix0", 128'(out_fix0), 128'(exp_f0));
    cmp(tag, "R4", "out_fix1", 128'(out_fix1), 128'(exp_f1));
    cmp(tag, "R6", "out_unc_half", 128'(out_unc_half), 128'(exp_unc));
    cmp(tag, "R8", "out_unc_line", 128'(out_unc_line), 128'(exp_line));
    cmp(tag, "R9", "out_unc_access", 128'(out_unc_access), 128'(exp_acc));
    if (case_bad) tests_failed++;
  endtask

  task automatic drive_inputs();
    in_data = drv_data;
    in_chk  = drv_chk;
    in_addr = drv_addr;
    in_half = drv_half;
  endtask

  // one accepted read, result sampled on the falling edge after capture
  task automatic do_read(input string tag);
    @(negedge clk);
    drive_inputs();
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag);
  endtask

  task automatic simple(input string tag, input string req, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL [%s] %s act=%0b exp=%0b", tag, req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL [watchdog] R11 act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256; v++)
        if ($countones(8'(v)) == w && cnt < 64) begin bdc[cnt] = 8'(v); cnt++; end
    cnt = 0;
    for (int w = 2; w <= 4; w += 2)
      for (int v = 1; v < 256; v++)
        if ($countones(8'(v)) == w && cnt < 9) begin bac[cnt] = 8'(v); cnt++; end

    rst_n = 1'b0; ecc_en = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_data = '0; in_chk = '0; in_addr = '0; in_half = 1'b0;
    repeat (3) @(negedge clk);
    simple("reset", "R13 out_valid", out_valid, 1'b0);
    simple("reset", "R13 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [46:0] e;
      e = TV[i];
      prep(pattern(e[46:45]), e[44:37], e[36:29], e[28:21], e[20:13], e[12:5], e[4],
           1'b1, e[3:2], e[1:0]);
      do_read($sformatf("table row %0d", i));
    end

    // R2 R3 R5: every single position, lower and upper halves at once
    for (int idx = 0; idx < 72; idx++) begin
      prep(pattern(2'd3), 8'(idx), NA, 8'(71 - idx), NA, 8'h00, idx[0], 1'b1, 2'b11, 2'b00);
      do_read($sformatf("R2 R3 sweep %0d", idx));
    end

    // R7: each read-address bit on its own
    for (int ab = 0; ab < AW; ab++) begin
      prep(pattern(2'd2), NA, NA, NA, NA, 8'(1 << ab), ab[0], 1'b1, 2'b00, 2'b11);
      do_read($sformatf("R7 addr bit %0d", ab));
    end

    // R10: checking disabled, faults pass through silently
    ecc_en = 1'b0;
    prep(pattern(2'd3), 8'd3, 8'd9, 8'd66, NA, 8'h04, 1'b1, 1'b0, 2'b00, 2'b00);
    do_read("R10 disabled");
    ecc_en = 1'b1;

    // R12: stall holds the result, then the next read follows
    begin
      logic [127:0] held;
      prep(pattern(2'd1), 8'd7, NA, NA, NA, 8'h00, 1'b0, 1'b1, 2'b01, 2'b00);
      held = exp_data;
      @(negedge clk);
      drive_inputs();
      in_valid = 1'b1;
      out_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      prep(pattern(2'd2), NA, NA, 8'd20, NA, 8'h00, 1'b1, 1'b1, 2'b10, 2'b00);
      drive_inputs();
      simple("R12 stall", "R12 in_ready", in_ready, 1'b0);
      @(posedge clk);
      @(negedge clk);
      simple("R12 stall", "R12 out_valid", out_valid, 1'b1);
      tests_run++;
      if (out_data !== held) begin
        tests_failed++;
        $display("FAIL [R12 stall] R12 out_data act=%h exp=%h", out_data, held);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_out("R11 after stall");
    end

    // R13: reset drops a pending result
    prep(pattern(2'd0), NA, NA, NA, NA, 8'h00, 1'b0, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    drive_inputs();
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    simple("R13 pending", "R13 out_valid before", out_valid, 1'b1);
    rst_n = 1'b0;
    #1;
    simple("R13 pending", "R13 out_valid", out_valid, 1'b0);
    simple("R13 pending", "R13 in_ready", in_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule